// File: doc/BRIEF.md
# DMA Channel Passing Serializer

This block sits between seven legacy ISA DMA request lines and a primary DMA arbiter that speaks a two-pin serial protocol. Instead of one request and one acknowledge wire per channel, the block reports the whole request picture as a short serial frame on a single active-low request pin. It also listens on a single active-low grant pin for a short serial word that names one channel, and it turns that word into the matching active-low DMA acknowledge.

The request inputs are asynchronous to the PCI clock, so they pass through a synchronizer of `SYNC_STAGES` flops first. Whenever the synchronized request set differs from the set last reported, and no frame is in flight, the block sends a frame: one low start bit, then eight slots for channels 0 to 7 in ascending order, one slot per clock, then at least one idle-high clock. The grant side waits for a low start bit, then takes three channel-number bits, least significant first, and updates a single held acknowledge. The acknowledge stays held until its request is withdrawn or another grant arrives.

Channel 4 is absent: it has no request input and no acknowledge output. The seven-bit vectors use index 0..3 for channels 0..3 and index 4..6 for channels 5..7. Only plain control pins exist on this block; there is no data stream and therefore no valid/ready handshake or back-pressure.

Top module: `dmacp_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, the request pin is high and all seven acknowledge outputs are high.
- R2: A request frame is a low start bit followed by eight slots, one per clock, for channels 0,1,2,3,4,5,6,7 in that order; a slot is low exactly when that channel's request was asserted when the frame started.
- R3: The channel 4 slot (the fifth slot after the start bit) is always high.
- R4: A frame starts when the synchronized request vector differs from the vector last reported; with the serializer idle the start bit appears on the pin `SYNC_STAGES`+1 clocks after the input change, and no frame is sent while the vector is unchanged.
- R5: A frame in flight is never cut short: its content is the snapshot taken at its start, a change during the frame is reported by a following frame, and the pin is high for at least one clock between frames.
- R6: A grant word is a low start bit then three bits giving the channel number, least significant bit first, bit value equal to the pin level (high is 1); the matching acknowledge goes low on the clock edge that samples the third bit.
- R7: A grant word carrying channel 4 is ignored: the acknowledge outputs keep their previous values.
- R8: A grant for a channel whose synchronized request is inactive leaves every acknowledge high.
- R9: A held acknowledge is released `SYNC_STAGES`+1 clocks after its own request input is deasserted; deasserting a different channel's request has no effect on it.
- R10: A new grant replaces the held acknowledge, and at no time is more than one acknowledge low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| dreq_i | input | 7 | ISA DMA requests, active high; index 0..3 = ch0..3, 4..6 = ch5..7 |
| gnt_ser_n_i | input | 1 | Serial grant pin, active low, idles high |
| req_ser_n_o | output | 1 | Serial request pin, active low, idles high |
| dack_n_o | output | 7 | DMA acknowledges, active low; same index map as dreq_i |

## Verification
The request side is swept through all 128 request vectors in an order where each differs from the last, so every slot is seen both low and high and any slot swap, inverted slot or channel 4 leak shows in the decoded frame; the start-bit delay is measured on each. Changes injected partway through a frame, including a change that is undone before the frame ends, separate correct snapshot-and-compare behaviour from a serializer that restarts, corrupts the frame or sends redundant frames. The grant side is driven with all eight channel numbers while every request is active, which exposes a reversed bit order or a wrong index map, and with grants to idle channels, channel 4 grants and request withdrawals on matching and non-matching channels, which separate replace, ignore and release behaviour.

// File: rtl/dmacp_pkg.sv
package dmacp_pkg;
  localparam int unsigned LEG_CHANS = 7;
  localparam int unsigned SLOTS     = 8;
  localparam int unsigned CH_W      = $clog2(SLOTS);
  localparam int unsigned SKIP_SLOT = 4;

  typedef enum logic [1:0] {TX_IDLE, TX_SLOTS, TX_GAP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_B0, RX_B1, RX_B2} rx_state_e;

  function automatic logic [CH_W-1:0] slot_of_idx(input int unsigned idx);
    if (idx < SKIP_SLOT) return CH_W'(idx);
    else                 return CH_W'(idx + 1);
  endfunction

  function automatic logic [SLOTS-1:0] expand_req(input logic [LEG_CHANS-1:0] v);
    logic [SLOTS-1:0] e;
    for (int s = 0; s < SLOTS; s++) begin
      if (s == SKIP_SLOT)     e[s] = 1'b0;
      else if (s < SKIP_SLOT) e[s] = v[s];
      else                    e[s] = v[s-1];
    end
    return e;
  endfunction
endpackage

// File: rtl/dmacp_sync.sv
module dmacp_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dmacp_req_ser.sv
module dmacp_req_ser
  import dmacp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LEG_CHANS-1:0] req_s_i,
  output logic                 ser_n_o
);
  tx_state_e            state;
  logic [CH_W-1:0]      slot;
  logic [SLOTS-1:0]     snap;
  logic [LEG_CHANS-1:0] sent;
  logic                 pin_q;

  localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      slot  <= '0;
      snap  <= '0;
      sent  <= '0;
      pin_q <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          if (req_s_i != sent) begin
            snap  <= expand_req(req_s_i);
            sent  <= req_s_i;
            slot  <= '0;
            pin_q <= 1'b0;
            state <= TX_SLOTS;
          end else begin
            pin_q <= 1'b1;
          end
        end
        TX_SLOTS: begin
          pin_q <= ~snap[slot];
          slot  <= slot + 1'b1;
          if (slot == LAST_SLOT) state <= TX_GAP;
        end
        default: begin
          pin_q <= 1'b1;
          state <= TX_IDLE;
        end
      endcase
    end
  end

  assign ser_n_o = pin_q;
endmodule

// File: rtl/dmacp_gnt_dec.sv
module dmacp_gnt_dec
  import dmacp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gnt_n_i,
  input  logic [LEG_CHANS-1:0] req_s_i,
  output logic [LEG_CHANS-1:0] ack_o
);
  rx_state_e            state;
  logic [CH_W-2:0]      low_bits;
  logic [CH_W-1:0]      gch;
  logic                 fire;
  logic                 usable;
  logic [LEG_CHANS-1:0] hit;
  logic [LEG_CHANS-1:0] ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      low_bits <= '0;
    end else begin
      case (state)
        RX_IDLE: if (!gnt_n_i) state <= RX_B0;
        RX_B0: begin
          low_bits[0] <= gnt_n_i;
          state       <= RX_B1;
        end
        RX_B1: begin
          low_bits[1] <= gnt_n_i;
          state       <= RX_B2;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // channel number is complete in the cycle that sees its top bit
  assign gch    = {gnt_n_i, low_bits};
  assign fire   = (state == RX_B2);
  assign usable = (gch != CH_W'(SKIP_SLOT));

  always_comb begin
    for (int i = 0; i < LEG_CHANS; i++) hit[i] = (gch == slot_of_idx(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ack_q <= '0;
    else if (fire && usable) ack_q <= hit & req_s_i;
    else                     ack_q <= ack_q & req_s_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/dmacp_bridge.sv
module dmacp_bridge
  import dmacp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LEG_CHANS-1:0] dreq_i,
  input  logic                 gnt_ser_n_i,
  output logic                 req_ser_n_o,
  output logic [LEG_CHANS-1:0] dack_n_o
);
  logic [LEG_CHANS-1:0] req_s;
  logic [LEG_CHANS-1:0] ack;

  dmacp_sync #(.W(LEG_CHANS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dreq_i),
    .q_o   (req_s)
  );

  dmacp_req_ser u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s_i (req_s),
    .ser_n_o (req_ser_n_o)
  );

  dmacp_gnt_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .gnt_n_i (gnt_ser_n_i),
    .req_s_i (req_s),
    .ack_o   (ack)
  );

  assign dack_n_o = ~ack;
endmodule

// File: rtl/dmacp_chk.sv
module dmacp_chk
  import dmacp_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ser_n,
  input logic                 gnt_ser_n,
  input logic [LEG_CHANS-1:0] dack_n,
  input logic [LEG_CHANS-1:0] req_s
);
  // frame position seen on the request pin: 1..8 = slots, 9 = gap
  logic [3:0] pos;
  // grant word position seen on the grant pin: 1..3 = bits
  logic [1:0] gpos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      gpos <= '0;
    end else begin
      if (pos == 4'd0) begin
        if (!req_ser_n) pos <= 4'd1;
      end else if (pos == 4'd9) pos <= 4'd0;
      else                      pos <= pos + 4'd1;

      if (gpos == 2'd0) begin
        if (!gnt_ser_n) gpos <= 2'd1;
      end else gpos <= gpos + 2'd1;
    end
  end

  // R10
  onehot_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  // R3
  ch4_slot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 4'd5) |-> req_ser_n);

  // R5
  gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 4'd9) |-> req_ser_n);

  // R8
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dack_n & ~$past(req_s)) == '0));

  // R6
  ack_only_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~dack_n & $past(dack_n))) |-> ($past(gpos) == 2'd3));
endmodule

bind dmacp_bridge dmacp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ser_n (req_ser_n_o),
  .gnt_ser_n (gnt_ser_n_i),
  .dack_n    (dack_n_o),
  .req_s     (req_s)
);

// File: tb/sim_dmacp_bridge.sv
module sim_dmacp_bridge;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dreq = '0;
  logic       gnt_n = 1'b1;
  logic       req_n;
  logic [6:0] dack_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dmacp_bridge #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .gnt_ser_n_i(gnt_n),
    .req_ser_n_o(req_n), .dack_n_o(dack_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_frame(input logic [6:0] p);
    logic [7:0] f;
    for (int s = 0; s < 8; s++)
      f[s] = (s == 4) ? 1'b1 : ~p[(s < 4) ? s : s - 1];
    return f;
  endfunction

  // waits for a start bit, reads 8 slots and the gap; optional mid-frame drives
  task automatic read_frame(output logic [7:0] f, output int lat, output logic gap,
                            input int m1, input logic [6:0] v1,
                            input int m2, input logic [6:0] v2);
    lat = 0;
    f = '1;
    gap = 1'b0;
    do begin
      @(negedge clk);
      lat++;
    end while (req_n !== 1'b0 && lat < 40);
    for (int s = 0; s < 8; s++) begin
      if (s == m1) dreq = v1;
      if (s == m2) dreq = v2;
      @(negedge clk);
      f[s] = req_n;
    end
    @(negedge clk);
    gap = req_n;
  endtask

  task automatic quiet(input int n, output bit stayed);
    stayed = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_n !== 1'b1) stayed = 0;
    end
  endtask

  task automatic send_grant(input int ch);
    gnt_n = 1'b0;
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      gnt_n = ch[b];
    end
    @(negedge clk);
    gnt_n = 1'b1;
  endtask

  function automatic logic [6:0] ack_of(input int ch);
    return 7'(1 << ((ch < 4) ? ch : ch - 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] f;
    int lat;
    logic gap;
    bit stayed;
    logic [6:0] exp_ack;

    repeat (4) @(negedge clk);
    check(req_n === 1'b1, "R1 pin in reset", req_n, 1);
    check(dack_n === 7'h7F, "R1 acks in reset", dack_n, 7'h7F);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_n === 1'b1, "R1 pin after reset", req_n, 1);
    check(dack_n === 7'h7F, "R1 acks after reset", dack_n, 7'h7F);
    quiet(20, stayed);
    check(stayed, "R4 no frame without change", stayed, 1);

    // sweep every request vector, ending at zero
    for (int k = 1; k <= 128; k++) begin
      logic [6:0] p;
      p = 7'(k % 128);
      dreq = p;
      read_frame(f, lat, gap, -1, '0, -1, '0);
      check(lat == SYNC + 1, "R4 start latency", lat, SYNC + 1);
      check(f === exp_frame(p), "R2 frame slots", f, exp_frame(p));
      check(f[4] === 1'b1, "R3 ch4 slot", f[4], 1);
      check(gap === 1'b1, "R5 gap after frame", gap, 1);
    end
    quiet(20, stayed);
    check(stayed, "R4 idle after sweep", stayed, 1);

    // change during a frame is sent afterwards
    dreq = 7'h2A;
    read_frame(f, lat, gap, 2, 7'h41, -1, '0);
    check(f === exp_frame(7'h2A), "R5 snapshot kept", f, exp_frame(7'h2A));
    check(gap === 1'b1, "R5 gap before follow-up", gap, 1);
    read_frame(f, lat, gap, -1, '0, -1, '0);
    check(lat == 1, "R5 back-to-back start", lat, 1);
    check(f === exp_frame(7'h41), "R5 follow-up frame", f, exp_frame(7'h41));

    // change that is undone before the frame ends: no extra frame
    dreq = 7'h7F;
    read_frame(f, lat, gap, 1, 7'h00, 3, 7'h7F);
    check(f === exp_frame(7'h7F), "R2 all-requested frame", f, exp_frame(7'h7F));
    quiet(20, stayed);
    check(stayed, "R4 no frame for undone change", stayed, 1);

    // grant sweep with every request active
    exp_ack = '0;
    for (int ch = 0; ch < 8; ch++) begin
      send_grant(ch);
      if (ch != 4) exp_ack = ack_of(ch);
      check(dack_n === ~exp_ack, (ch == 4) ? "R7 ch4 grant ignored" : "R6 grant decode",
            dack_n, ~exp_ack);
      check($countones(~dack_n) <= 1, "R10 single ack", $countones(~dack_n), 1);
    end

    // withdraw a different channel: held ack on ch7 stays
    dreq[0] = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    check(dack_n === ~ack_of(7), "R9 other request no effect", dack_n, ~ack_of(7));

    // withdraw the matching channel: release after SYNC+1 clocks
    dreq[6] = 1'b0;
    repeat (SYNC) @(negedge clk);
    check(dack_n === ~ack_of(7), "R9 held before release", dack_n, ~ack_of(7));
    @(negedge clk);
    check(dack_n === 7'h7F, "R9 released", dack_n, 7'h7F);

    // replace, then grant an idle channel
    send_grant(2);
    check(dack_n === ~ack_of(2), "R6 grant ch2", dack_n, ~ack_of(2));
    send_grant(5);
    check(dack_n === ~ack_of(5), "R10 grant replaces", dack_n, ~ack_of(5));
    send_grant(7);
    check(dack_n === 7'h7F, "R8 grant to idle channel", dack_n, 7'h7F);
    send_grant(0);
    check(dack_n === 7'h7F, "R8 grant to idle ch0", dack_n, 7'h7F);
    send_grant(3);
    check(dack_n === ~ack_of(3), "R6 grant ch3", dack_n, ~ack_of(3));
    send_grant(4);
    check(dack_n === ~ack_of(3), "R7 ch4 keeps ack", dack_n, ~ack_of(3));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule